// File: doc/BRIEF.md
# Cross-Clock Mailbox Bypass Register

This block gives two ports, each running on its own clock, a way to pass a single word to the other side without going through the bulk FIFO storage. There is one mailbox for each direction. When a port writes its outgoing mailbox, the word is captured in a register in the sender's clock domain. A toggle event then crosses into the receiver's domain through a two-flop synchronizer. There it raises a new-mail flag. The receiver reads the word and strobes its read input. That clears the flag and sends a toggle back to the sender, which drops its busy indication. Each port also has an output select that chooses between the incoming mailbox word and the word offered by the FIFO path.

The two clocks may be fully asynchronous or may share one source. The stored word stays stable for the whole time the sender is busy, so the receiver can sample it directly once the flag is up. Each direction is built from a sender state machine and a receiver state machine.

The sender machine has two states, TX_FREE and TX_BUSY. It moves TX_FREE→TX_BUSY on an accepted write. It moves TX_BUSY→TX_FREE when the synchronized acknowledge toggle equals its request toggle.

The receiver machine has two states, RX_EMPTY and RX_FULL. It moves RX_EMPTY→RX_FULL when the synchronized request toggle differs from its acknowledge toggle. It moves RX_FULL→RX_EMPTY on a read strobe.

Top module: `mbx_bypass`

## Requirements
- R1: After reset, both new-mail flags (`a_mail`, `b_mail`) and both busy outputs (`a_busy`, `b_busy`) are 0.
- R2: A write strobe while the sender's busy output is 0 stores the data word, and busy reads 1 after the next rising edge of the sender clock.
- R3: After an accepted write, the receiver's new-mail flag rises within 8 rising edges of the receiver clock.
- R4: While the receiver's select input is 1 and its flag is set, its data output equals the word the sender wrote.
- R5: While a port's select input is 0, its data output equals its FIFO word input.
- R6: A write strobe while the sender is busy is ignored: the stored word delivered to the receiver is unchanged.
- R7: A read strobe while the new-mail flag is set clears the flag at the next rising edge of the receiver clock.
- R8: A read strobe while the new-mail flag is clear has no effect. The flag stays 0, the sender stays free, and the next transfer behaves normally.
- R9: After the receiver reads, the sender's busy output returns to 0 within 8 rising edges of the sender clock.
- R10: The two directions operate independently, and transfers in both directions may overlap in time.
- R11: While no read strobe is applied, a set new-mail flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_wr | input | 1 | Port A write strobe into the A-to-B mailbox |
| a_wdata | input | W | Word written by port A |
| a_rd | input | 1 | Port A read strobe of the B-to-A mailbox |
| a_mbx_sel | input | 1 | Port A output select: 1 = mailbox word, 0 = FIFO word |
| a_fifo_q | input | W | FIFO word offered to port A |
| a_q | output | W | Port A read data |
| a_mail | output | 1 | New mail waiting for port A |
| a_busy | output | 1 | A-to-B mailbox holds an unread word |
| b_wr | input | 1 | Port B write strobe into the B-to-A mailbox |
| b_wdata | input | W | Word written by port B |
| b_rd | input | 1 | Port B read strobe of the A-to-B mailbox |
| b_mbx_sel | input | 1 | Port B output select: 1 = mailbox word, 0 = FIFO word |
| b_fifo_q | input | W | FIFO word offered to port B |
| b_q | output | W | Port B read data |
| b_mail | output | 1 | New mail waiting for port B |
| b_busy | output | 1 | B-to-A mailbox holds an unread word |

## Verification
The transfer path is tried in three ways:
- directed single transfers in each direction, which separate the write, flag, read and release phases;
- a second write while busy, which shows whether a busy sender overwrites the stored word;
- a read strobe with no mail pending, which shows whether a stray read sends a false acknowledge.

A seeded random run then mixes words, idle gaps and overlapping transfers in both directions. This exposes coupling between the two mailboxes and handshake timing that depends on the clock phases. A random FIFO word with the select low confirms that the output mux passes the FIFO path.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic {TX_FREE = 1'b0, TX_BUSY = 1'b1} tx_state_t;
    typedef enum logic {RX_EMPTY = 1'b0, RX_FULL = 1'b1} rx_state_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_sender.sv
module mbx_sender
    import mbx_pkg::*;
#(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         ack_s,
    output logic         req_t,
    output logic [W-1:0] word_q,
    output logic         busy
);
    tx_state_t st, nxt;

    always_comb begin
        nxt = st;
        unique case (st)
            TX_FREE: if (wr) nxt = TX_BUSY;
            TX_BUSY: if (ack_s == req_t) nxt = TX_FREE;
            default: nxt = TX_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_FREE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            req_t  <= 1'b0;
        end else if (st == TX_FREE && wr) begin
            word_q <= wdata;
            req_t  <= ~req_t;
        end
    end

    assign busy = (st == TX_BUSY);

    assert_busy_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !busy) |=> busy);
    assert_ignore_busy_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && busy) |=> ($stable(word_q) && $stable(req_t)));
endmodule

// File: rtl/mbx_receiver.sv
module mbx_receiver
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd,
    input  logic req_s,
    output logic ack_t,
    output logic mail
);
    rx_state_t st, nxt;

    always_comb begin
        nxt = st;
        unique case (st)
            RX_EMPTY: if (req_s != ack_t) nxt = RX_FULL;
            RX_FULL:  if (rd) nxt = RX_EMPTY;
            default:  nxt = RX_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_EMPTY;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   ack_t <= 1'b0;
        else if (st == RX_FULL && rd) ack_t <= ~ack_t;
    end

    assign mail = (st == RX_FULL);

    assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mail && rd) |=> !mail);
    assert_hold_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mail && !rd) |=> mail);
    assert_empty_read_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mail && rd) |=> $stable(ack_t));
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
    parameter int W = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic         tx_clk,
    input  logic         rx_clk,
    input  logic         rst_n,
    input  logic         tx_wr,
    input  logic [W-1:0] tx_data,
    output logic         tx_busy,
    input  logic         rx_rd,
    output logic         rx_mail,
    output logic [W-1:0] rx_word
);
    logic req_t, req_s, ack_t, ack_s;

    mbx_sender #(.W(W)) u_tx (
        .clk(tx_clk), .rst_n(rst_n), .wr(tx_wr), .wdata(tx_data),
        .ack_s(ack_s), .req_t(req_t), .word_q(rx_word), .busy(tx_busy)
    );

    mbx_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(rx_clk), .rst_n(rst_n), .d(req_t), .q(req_s)
    );

    mbx_receiver u_rx (
        .clk(rx_clk), .rst_n(rst_n), .rd(rx_rd), .req_s(req_s),
        .ack_t(ack_t), .mail(rx_mail)
    );

    mbx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(tx_clk), .rst_n(rst_n), .d(ack_t), .q(ack_s)
    );
endmodule

// File: rtl/mbx_bypass.sv
module mbx_bypass #(
    parameter int W = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         rst_n,
    input  logic         a_wr,
    input  logic [W-1:0] a_wdata,
    input  logic         a_rd,
    input  logic         a_mbx_sel,
    input  logic [W-1:0] a_fifo_q,
    output logic [W-1:0] a_q,
    output logic         a_mail,
    output logic         a_busy,
    input  logic         b_wr,
    input  logic [W-1:0] b_wdata,
    input  logic         b_rd,
    input  logic         b_mbx_sel,
    input  logic [W-1:0] b_fifo_q,
    output logic [W-1:0] b_q,
    output logic         b_mail,
    output logic         b_busy
);
    logic [W-1:0] word_a2b, word_b2a;

    mbx_channel #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_a2b (
        .tx_clk(clk_a), .rx_clk(clk_b), .rst_n(rst_n),
        .tx_wr(a_wr), .tx_data(a_wdata), .tx_busy(a_busy),
        .rx_rd(b_rd), .rx_mail(b_mail), .rx_word(word_a2b)
    );

    mbx_channel #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_b2a (
        .tx_clk(clk_b), .rx_clk(clk_a), .rst_n(rst_n),
        .tx_wr(b_wr), .tx_data(b_wdata), .tx_busy(b_busy),
        .rx_rd(a_rd), .rx_mail(a_mail), .rx_word(word_b2a)
    );

    assign a_q = a_mbx_sel ? word_b2a : a_fifo_q;
    assign b_q = b_mbx_sel ? word_a2b : b_fifo_q;
endmodule

// File: tb/test_mbx_bypass.sv
module test_mbx_bypass;
    localparam int W = 36;
    localparam int LIMIT = 8;

    logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
    logic a_wr = 0, a_rd = 0, a_mbx_sel = 1, b_wr = 0, b_rd = 0, b_mbx_sel = 1;
    logic [W-1:0] a_wdata = '0, a_fifo_q = '0, b_wdata = '0, b_fifo_q = '0;
    logic [W-1:0] a_q, b_q;
    logic a_mail, a_busy, b_mail, b_busy;

    int checks = 0, errors = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk_a = ~clk_a;
    always #7  clk_b = ~clk_b;

    mbx_bypass #(.W(W)) i_mbx_bypass (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .a_wr(a_wr), .a_wdata(a_wdata), .a_rd(a_rd), .a_mbx_sel(a_mbx_sel),
        .a_fifo_q(a_fifo_q), .a_q(a_q), .a_mail(a_mail), .a_busy(a_busy),
        .b_wr(b_wr), .b_wdata(b_wdata), .b_rd(b_rd), .b_mbx_sel(b_mbx_sel),
        .b_fifo_q(b_fifo_q), .b_q(b_q), .b_mail(b_mail), .b_busy(b_busy)
    );

    function automatic logic [W-1:0] exp_q(input logic sel, input logic [W-1:0] mail_w,
                                           input logic [W-1:0] fifo_w);
        return sel ? mail_w : fifo_w;
    endfunction

    function automatic logic [W-1:0] rnd_word();
        logic [W-1:0] v;
        v = {$urandom, $urandom};
        return v;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // A -> B transfer: write at A, wait for B flag, check word, read at B, wait A release
    task automatic xfer_ab(input logic [W-1:0] d, input bool_dup);
        int n;
        @(negedge clk_a); a_wr = 1; a_wdata = d;
        @(negedge clk_a); a_wr = 0;
        check("R2 a_busy after write", a_busy, 1);
        if (bool_dup) begin
            a_wr = 1; a_wdata = ~d;
            @(negedge clk_a); a_wr = 0;
        end
        n = 0;
        while (!b_mail && n <= LIMIT) begin @(negedge clk_b); n++; end
        check("R3 b_mail within bound", b_mail, 1);
        check(bool_dup ? "R6 word kept after busy write" : "R4 b_q mailbox word",
              b_q, exp_q(1'b1, d, b_fifo_q));
        @(negedge clk_b); b_rd = 1;
        @(negedge clk_b); b_rd = 0;
        check("R7 b_mail cleared by read", b_mail, 0);
        n = 0;
        while (a_busy && n <= LIMIT) begin @(negedge clk_a); n++; end
        check("R9 a_busy released", a_busy, 0);
    endtask

    task automatic xfer_ba(input logic [W-1:0] d);
        int n;
        @(negedge clk_b); b_wr = 1; b_wdata = d;
        @(negedge clk_b); b_wr = 0;
        check("R2 b_busy after write", b_busy, 1);
        n = 0;
        while (!a_mail && n <= LIMIT) begin @(negedge clk_a); n++; end
        check("R3 a_mail within bound", a_mail, 1);
        check("R4 a_q mailbox word", a_q, exp_q(1'b1, d, a_fifo_q));
        @(negedge clk_a); a_rd = 1;
        @(negedge clk_a); a_rd = 0;
        check("R7 a_mail cleared by read", a_mail, 0);
        n = 0;
        while (b_busy && n <= LIMIT) begin @(negedge clk_b); n++; end
        check("R9 b_busy released", b_busy, 0);
    endtask

    always @(posedge clk_a) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d0, d1;
        void'($urandom(32'd1234));
        #35 rst_n = 1;
        @(negedge clk_a);
        // R1 reset state
        check("R1 a_mail", a_mail, 0);
        check("R1 b_mail", b_mail, 0);
        check("R1 a_busy", a_busy, 0);
        check("R1 b_busy", b_busy, 0);

        // directed transfers
        xfer_ab(36'h9_1234_5678, 1'b0);
        xfer_ba(36'h0_FFFF_0001);
        xfer_ab(36'hA_5A5A_5A5A, 1'b1);   // R6 second write while busy

        // R11 flag hold without read
        @(negedge clk_a); a_wr = 1; a_wdata = 36'h3_3333_3333;
        @(negedge clk_a); a_wr = 0;
        repeat (LIMIT + 2) @(negedge clk_b);
        check("R11 b_mail held", b_mail, 1);
        repeat (5) @(negedge clk_b);
        check("R11 b_mail still held", b_mail, 1);
        check("R11 a_busy held", a_busy, 1);
        @(negedge clk_b); b_rd = 1;
        @(negedge clk_b); b_rd = 0;
        repeat (LIMIT) @(negedge clk_a);
        check("R9 a_busy released after hold", a_busy, 0);

        // R8 read with no mail pending
        @(negedge clk_b); b_rd = 1;
        repeat (3) @(negedge clk_b);
        b_rd = 0;
        repeat (LIMIT) @(negedge clk_b);
        check("R8 b_mail stays clear", b_mail, 0);
        check("R8 a_busy stays clear", a_busy, 0);
        xfer_ab(36'h1_0000_0001, 1'b0);

        // R5 FIFO path through the mux
        for (int i = 0; i < 4; i++) begin
            @(negedge clk_b);
            b_mbx_sel = 0; b_fifo_q = rnd_word();
            @(negedge clk_b);
            check("R5 b_q FIFO word", b_q, exp_q(1'b0, '0, b_fifo_q));
            @(negedge clk_a);
            a_mbx_sel = 0; a_fifo_q = rnd_word();
            @(negedge clk_a);
            check("R5 a_q FIFO word", a_q, exp_q(1'b0, '0, a_fifo_q));
        end
        a_mbx_sel = 1; b_mbx_sel = 1;

        // R10 random overlapping transfers in both directions
        for (int i = 0; i < 40; i++) begin
            d0 = rnd_word();
            d1 = rnd_word();
            fork
                begin
                    repeat ($urandom_range(0, 4)) @(negedge clk_a);
                    xfer_ab(d0, ($urandom_range(0, 3) == 0));
                end
                begin
                    repeat ($urandom_range(0, 4)) @(negedge clk_b);
                    xfer_ba(d1);
                end
            join
        end
        check("R10 both free after overlap", {a_busy, b_busy}, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule